// File: doc/BRIEF.md
# Flash Byte-Write Arbiter with Collision Flags

This block sits on a processor's external-data store path in front of a flash array. A periodic compute engine also fetches its code from that flash. A software-controlled program-enable bit decides where each store goes. When the bit is clear, the store goes to RAM. When it is set, the store is a flash byte-program request, and the block decides whether the request may run.

A request is refused if the compute engine is busy or is about to start a pass. The refusal is recorded in a sticky flag. An accepted byte program holds a write-busy output for a fixed number of clock cycles, which stands in for the program time of the flash cell. If the engine's next pass falls due while a program is still running, the block cancels that pass and lets the write finish. This is recorded in a second sticky flag.

The block also marks the start of each idle gap of the engine with a pulse that firmware can poll. This lets firmware time a write into the gap.

Top module: `flash_wr_arb`

## Requirements
- R1: While the program-enable bit (`pwe`) is 0, a store (`st_valid`) raises `ram_we` in the same cycle and `fl_we` stays 0. `mem_addr` and `mem_data` always equal `st_addr` and `st_data`.
- R2: A write to the program-enable bit (`cfg_we`) takes effect at the next clock edge only while `gie` is 0. While `gie` is 1 the bit keeps its value.
- R3: The program-enable bit is never cleared by the block itself. It keeps its value across accepted, refused and dropped flash writes.
- R4: A flash store (`st_valid` with `pwe` set) in a cycle where `eng_busy` or `eng_pass_due` is 1 is refused: `fl_we` stays 0, and `col0_irq` is 1 from the next cycle.
- R5: A flash store with no engine activity and `wr_busy` low raises `fl_we` in the same cycle. `wr_busy` is then 1 for exactly PROG_CYCLES cycles, starting at the next edge.
- R6: A flash store while `wr_busy` is 1 and the engine is idle is dropped. `fl_we` stays 0, no flag changes and the running program time is not restarted.
- R7: When `eng_pass_due` is 1 while `wr_busy` is 1, `pass_skip` is 1 and `pass_go` is 0 in that cycle. `col1_irq` is 1 from the next cycle, and `wr_busy` continues its count unchanged.
- R8: When `eng_pass_due` is 1 while `wr_busy` is 0, `pass_go` is 1 and `pass_skip` is 0. Neither output is ever 1 without `eng_pass_due`.
- R9: `col0_irq` and `col1_irq` are sticky. They are cleared by a 1 on `flag_clr[0]` and `flag_clr[1]` respectively. A set in the same cycle wins over the clear.
- R10: `idle_pulse` is 1 in exactly the cycles where `eng_busy` is 0 and was 1 at the previous clock edge.
- R11: After reset, `pwe`, `wr_busy`, `col0_irq` and `col1_irq` are 0. `rst_n` is applied asynchronously and released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gie | input | 1 | Global interrupt enable; blocks program-enable updates |
| cfg_we | input | 1 | Write strobe for the program-enable bit |
| cfg_wdata | input | 1 | Value written to the program-enable bit |
| st_valid | input | 1 | Processor data store strobe |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data byte |
| eng_busy | input | 1 | Compute engine is executing from flash |
| eng_pass_due | input | 1 | Engine's next code pass would start this cycle |
| flag_clr | input | 2 | Write-1-to-clear for the two collision flags |
| pwe | output | 1 | Current program-enable bit |
| ram_we | output | 1 | Store steered to RAM |
| fl_we | output | 1 | Flash byte program launched |
| mem_addr | output | AW | Address to RAM or flash |
| mem_data | output | DW | Data to RAM or flash |
| wr_busy | output | 1 | Flash byte program in progress |
| pass_go | output | 1 | Engine pass allowed to start |
| pass_skip | output | 1 | Engine pass cancelled by a running write |
| col0_irq | output | 1 | Sticky flag: write refused during engine activity |
| col1_irq | output | 1 | Sticky flag: pass skipped for a running write |
| idle_pulse | output | 1 | Engine idle gap begins |

## Verification
The bench builds the block with PROG_CYCLES set to 12 and AW set to 8. With a program window this short, thousands of random cycles contain many complete programs, many pass-due events that land inside a window, and many that land just outside it. The dropped-store and skipped-pass cases therefore come up often. The small address width keeps the pass-through check cheap. It still exercises every address bit.

// File: rtl/fwa_pkg.sv
package fwa_pkg;
  localparam int unsigned NUM_COL = 2;
  typedef enum logic [0:0] {
    COL_REFUSED = 1'b0,
    COL_SKIPPED = 1'b1
  } col_idx_e;
endpackage

// File: rtl/fwa_rst_sync.sv
module fwa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/fwa_prog_timer.sv
module fwa_prog_timer #(
  parameter int unsigned PROG_CYCLES = 420
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int unsigned CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(PROG_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = load | busy;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = LOAD_VAL;
    else if (busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fwa_sticky_flag.sv
module fwa_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_d, flag_en;

  assign flag_en = set | clr;

  always_comb begin
    flag_d = flag;
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_en) flag <= flag_d;
  end
endmodule

// File: rtl/fwa_fall_det.sv
module fwa_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign fall = sig_q & ~sig;
endmodule

// File: rtl/flash_wr_arb.sv
module flash_wr_arb #(
  parameter int unsigned AW          = 16,
  parameter int unsigned DW          = 8,
  parameter int unsigned PROG_CYCLES = 420
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gie,
  input  logic          cfg_we,
  input  logic          cfg_wdata,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          eng_busy,
  input  logic          eng_pass_due,
  input  logic [1:0]    flag_clr,
  output logic          pwe,
  output logic          ram_we,
  output logic          fl_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          wr_busy,
  output logic          pass_go,
  output logic          pass_skip,
  output logic          col0_irq,
  output logic          col1_irq,
  output logic          idle_pulse
);
  import fwa_pkg::*;

  logic rst_sync_n;
  logic pwe_q, pwe_d, pwe_en;
  logic fl_req, eng_active, accept, refuse;
  logic [NUM_COL-1:0] col_set, col_flag;

  fwa_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_sync_n)
  );

  // program-enable bit: software may update it only with interrupts off
  assign pwe_en = cfg_we & ~gie;
  assign pwe_d  = cfg_wdata;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pwe_q <= 1'b0;
    else if (pwe_en)  pwe_q <= pwe_d;
  end

  // steering and arbitration
  assign fl_req     = st_valid & pwe_q;
  assign eng_active = eng_busy | eng_pass_due;
  assign accept     = fl_req & ~eng_active & ~wr_busy;
  assign refuse     = fl_req & eng_active;

  assign ram_we    = st_valid & ~pwe_q;
  assign fl_we     = accept;
  assign mem_addr  = st_addr;
  assign mem_data  = st_data;
  assign pwe       = pwe_q;
  assign pass_skip = eng_pass_due & wr_busy;
  assign pass_go   = eng_pass_due & ~wr_busy;

  fwa_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .load(accept), .busy(wr_busy)
  );

  assign col_set[COL_REFUSED] = refuse;
  assign col_set[COL_SKIPPED] = pass_skip;

  for (genvar g = 0; g < NUM_COL; g++) begin : g_col
    fwa_sticky_flag u_flag (
      .clk(clk), .rst_n(rst_sync_n),
      .set(col_set[g]), .clr(flag_clr[g]), .flag(col_flag[g])
    );
  end

  assign col0_irq = col_flag[COL_REFUSED];
  assign col1_irq = col_flag[COL_SKIPPED];

  fwa_fall_det u_idle (
    .clk(clk), .rst_n(rst_sync_n), .sig(eng_busy), .fall(idle_pulse)
  );
endmodule

// File: rtl/fwa_checker.sv
module fwa_checker (
  input logic       clk,
  input logic       rst_ok,
  input logic       gie,
  input logic       cfg_we,
  input logic       st_valid,
  input logic       eng_busy,
  input logic       eng_pass_due,
  input logic [1:0] flag_clr,
  input logic       pwe,
  input logic       ram_we,
  input logic       fl_we,
  input logic       wr_busy,
  input logic       pass_go,
  input logic       pass_skip,
  input logic       col0_irq,
  input logic       col1_irq,
  input logic       idle_pulse
);
  p_ram_flash_excl_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    !(ram_we && fl_we));

  p_pwe_locked_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (gie || !cfg_we) |=> $stable(pwe));

  p_refuse_no_prog_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (st_valid && pwe && (eng_busy || eng_pass_due)) |-> !fl_we);

  p_refuse_flag_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (st_valid && pwe && eng_busy) |=> col0_irq);

  p_prog_starts_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    fl_we |=> wr_busy);

  p_no_launch_busy_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_busy |-> !fl_we);

  p_skip_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (eng_pass_due && wr_busy) |-> (pass_skip && !pass_go));

  p_skip_flag_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    pass_skip |=> col1_irq);

  p_pass_excl_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !(pass_go && pass_skip));

  p_sticky0_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (col0_irq && !flag_clr[0]) |=> col0_irq);

  p_sticky1_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (col1_irq && !flag_clr[1]) |=> col1_irq);

  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    idle_pulse |-> !eng_busy);
endmodule

bind flash_wr_arb fwa_checker u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .gie(gie), .cfg_we(cfg_we),
  .st_valid(st_valid), .eng_busy(eng_busy), .eng_pass_due(eng_pass_due),
  .flag_clr(flag_clr), .pwe(pwe), .ram_we(ram_we), .fl_we(fl_we),
  .wr_busy(wr_busy), .pass_go(pass_go), .pass_skip(pass_skip),
  .col0_irq(col0_irq), .col1_irq(col1_irq), .idle_pulse(idle_pulse)
);

// File: tb/flash_wr_arb_test.sv
module flash_wr_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int PROG = 12;

  logic clk, rst_n, gie, cfg_we, cfg_wdata, st_valid, eng_busy, eng_pass_due;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic [1:0] flag_clr;
  logic pwe, ram_we, fl_we, wr_busy, pass_go, pass_skip, col0_irq, col1_irq, idle_pulse;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int checks = 0, errors = 0;
  // bench model state
  bit m_pwe, m_c0, m_c1, m_bq;
  int m_cnt;

  flash_wr_arb #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG)) uut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_accept();
    return st_valid && m_pwe && !eng_busy && !eng_pass_due && m_cnt == 0;
  endfunction

  function automatic bit exp_refuse();
    return st_valid && m_pwe && (eng_busy || eng_pass_due);
  endfunction

  // inputs already driven at negedge; check comb outputs, step, check state
  task automatic cycle();
    bit acc, ref0, skp;
    #1;
    acc  = exp_accept();
    ref0 = exp_refuse();
    skp  = eng_pass_due && m_cnt != 0;
    chk("R1", "ram_we", int'(ram_we), int'(st_valid && !m_pwe));
    chk("R1", "mem_addr", int'(mem_addr), int'(st_addr));
    chk("R1", "mem_data", int'(mem_data), int'(st_data));
    chk("R5/R6", "fl_we", int'(fl_we), int'(acc));
    chk("R7", "pass_skip", int'(pass_skip), int'(skp));
    chk("R8", "pass_go", int'(pass_go), int'(eng_pass_due && m_cnt == 0));
    chk("R10", "idle_pulse", int'(idle_pulse), int'(m_bq && !eng_busy));
    if (cfg_we && !gie) m_pwe = cfg_wdata;
    if (acc) m_cnt = PROG; else if (m_cnt != 0) m_cnt--;
    m_c0 = ref0 || (m_c0 && !flag_clr[0]);
    m_c1 = skp  || (m_c1 && !flag_clr[1]);
    m_bq = eng_busy;
    @(posedge clk);
    #1;
    chk("R2/R3", "pwe", int'(pwe), int'(m_pwe));
    chk("R5", "wr_busy", int'(wr_busy), int'(m_cnt != 0));
    chk("R4/R9", "col0_irq", int'(col0_irq), int'(m_c0));
    chk("R7/R9", "col1_irq", int'(col1_irq), int'(m_c1));
    @(negedge clk);
  endtask

  task automatic idle_in();
    gie = 0; cfg_we = 0; cfg_wdata = 0; st_valid = 0; st_addr = '0; st_data = '0;
    eng_busy = 0; eng_pass_due = 0; flag_clr = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    idle_in();
    rst_n = 0;
    m_pwe = 0; m_c0 = 0; m_c1 = 0; m_bq = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "pwe", int'(pwe), 0);
    chk("R11", "wr_busy", int'(wr_busy), 0);
    chk("R11", "col0_irq", int'(col0_irq), 0);
    chk("R11", "col1_irq", int'(col1_irq), 0);

    // R1 RAM store with pwe clear
    st_valid = 1; st_addr = 8'h3c; st_data = 8'ha5; cycle(); idle_in();
    // R2 pwe write ignored with gie set
    gie = 1; cfg_we = 1; cfg_wdata = 1; cycle(); idle_in();
    // set pwe with gie clear
    cfg_we = 1; cfg_wdata = 1; cycle(); idle_in();
    // R5 accepted write, then R6 store during program, R7 pass during program
    st_valid = 1; st_addr = 8'h10; st_data = 8'h77; cycle(); idle_in();
    st_valid = 1; st_addr = 8'h11; cycle(); idle_in();
    repeat (3) cycle();
    eng_pass_due = 1; cycle(); idle_in();
    repeat (PROG) cycle();
    // R8 pass with no write
    eng_pass_due = 1; cycle(); idle_in();
    // R4 refused: engine busy, then R10 falling edge
    eng_busy = 1; st_valid = 1; cycle(); idle_in();
    eng_busy = 1; cycle(); idle_in();
    cycle();
    // R4 refused by pass due in same cycle
    eng_pass_due = 1; st_valid = 1; cycle(); idle_in();
    // R9 set and clear in same cycle: set wins; then clear
    eng_busy = 1; st_valid = 1; flag_clr = 2'b01; cycle(); idle_in();
    flag_clr = 2'b11; cycle(); idle_in();
    chk("R9", "col0 cleared", int'(col0_irq), 0);
    chk("R9", "col1 cleared", int'(col1_irq), 0);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      gie          = ($urandom % 4) == 0;
      cfg_we       = ($urandom % 16) == 0;
      cfg_wdata    = ($urandom % 4) != 0;
      st_valid     = ($urandom % 3) == 0;
      st_addr      = AW'($urandom);
      st_data      = DW'($urandom);
      eng_busy     = ($urandom % 8) < 3;
      eng_pass_due = ($urandom % 10) == 0;
      flag_clr     = (($urandom % 12) == 0) ? 2'($urandom) : 2'b00;
      cycle();
    end
    idle_in();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule